// File: doc/BRIEF.md
# Write-Back Fully-Associative Data Cache

This block is a very small data cache that sits between a processor load/store port and a byte-wide memory port. Any line can hold any block, because the whole tag is compared against every line at once. Stores never go to memory directly. A store writes into the cached line and marks the line as modified, using one dirty flag for each line. A load or store that misses first picks a line to replace. If that line holds modified data, the cache copies the whole block out to memory. It then fetches the requested block and completes the access from the newly filled line.

With the default parameters there are two lines of two bytes each, and the byte address is 5 bits wide. The low address bit selects the byte inside a block, and the upper four bits form the tag. The processor side sees one request at a time. `req_ready` is high only while the cache is idle. Every accepted request is answered by one `rsp_valid` pulse that carries the byte and a hit flag. Two free-running counters record how many accepted accesses hit and how many missed.

Top module: `wbc_cache`

## Requirements
- R1: After a synchronous reset, every line is invalid and both counters read zero. `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: A load whose tag matches a valid line returns the cached byte with `rsp_hit`=1. It issues no `mem_req` between acceptance and response.
- R3: A store that hits writes `req_wdata` into the line and marks the line dirty. It issues no memory access. Its response echoes the stored byte with `rsp_hit`=1.
- R4: On a miss, the block is read from memory one byte per request. The read addresses are `{req_addr[4:1], offset}`, in ascending offset order. The filled line becomes valid and clean, and the response then carries `rsp_hit`=0.
- R5: The line to be replaced is the lowest-numbered invalid line. When every line is valid, it is the line touched least recently, where each completed access counts as a touch.
- R6: Replacing a clean line causes no memory write.
- R7: Replacing a dirty line first writes every byte of its block to memory, in ascending offset order. The write address is formed from the victim's stored tag and the offset. All of these writes come before the first read of the new block.
- R8: A store that misses fills the block, merges the stored byte and leaves the line dirty. Memory does not receive that byte until the line is later replaced.
- R9: `hit_count` and `miss_count` each rise by exactly one for every accepted access that hits or misses respectively.
- R10: `req_ready` is 0 from the cycle after acceptance until the response. `rsp_valid` is a single-cycle pulse, given in a cycle in which `req_ready` is 1 again.
- R11: Memory read data is taken exactly one clock after the read request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Cache idle, request is accepted this cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Loaded byte, or the stored byte for a store |
| rsp_hit | output | 1 | Access hit in the cache |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the read request |
| hit_count | output | CNT_W | Accepted hits since reset |
| miss_count | output | CNT_W | Accepted misses since reset |

## Verification
The bench uses the default build: two lines, 2-byte blocks and a 5-bit address space. At that size all 32 addresses can be swept exhaustively, and the final memory image can be compared byte by byte against an arithmetic reference. A random phase confined to four blocks forces frequent replacements of both clean and dirty lines, and so exercises the replacement order. A second phase over the full address space mixes in cold misses. For every access, the bench checks how many memory reads and writes occurred, which addresses they used and in what order, as well as the returned byte and the hit flag.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WRITEBACK = 2'd1,
    ST_FILL      = 2'd2,
    ST_RESPOND   = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_array.sv
module wbc_tag_array #(
  parameter int LINES = 2,
  parameter int TAG_W = 4,
  parameter int WAY_W = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [TAG_W-1:0]               lookup_tag,
  output logic                           hit,
  output logic [WAY_W-1:0]               hit_way,
  input  logic                           alloc_en,
  input  logic [WAY_W-1:0]               alloc_way,
  input  logic [TAG_W-1:0]               alloc_tag,
  input  logic                           dirty_en,
  input  logic [WAY_W-1:0]               dirty_way,
  input  logic                           inval_en,
  input  logic [WAY_W-1:0]               inval_way,
  output logic [LINES-1:0]               valid_vec,
  output logic [LINES-1:0]               dirty_vec,
  output logic [LINES-1:0][TAG_W-1:0]    tag_vec
);

  logic [LINES-1:0] match;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             v_r;
    logic             d_r;
    logic [TAG_W-1:0] t_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_r <= 1'b0;
        d_r <= 1'b0;
        t_r <= '0;
      end else begin
        if (inval_en && inval_way == WAY_W'(i)) begin
          v_r <= 1'b0;
          d_r <= 1'b0;
        end
        if (alloc_en && alloc_way == WAY_W'(i)) begin
          v_r <= 1'b1;
          d_r <= 1'b0;
          t_r <= alloc_tag;
        end
        if (dirty_en && dirty_way == WAY_W'(i)) d_r <= 1'b1;
      end
    end

    assign valid_vec[i] = v_r;
    assign dirty_vec[i] = d_r;
    assign tag_vec[i]   = t_r;
    assign match[i]     = v_r && (t_r == lookup_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end
  assign hit = |match;

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst) $onehot0(match)); // R2

endmodule

// File: rtl/wbc_lru.sv
module wbc_lru #(
  parameter int LINES = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [LINES-1:0] valid_vec,
  output logic [WAY_W-1:0] victim_way
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(LINES - 1);

  logic [WAY_W-1:0] age_q [LINES];
  logic [LINES-1:0] is_oldest;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < LINES; j++) age_q[j] <= WAY_W'(j);
    end else if (touch_en) begin
      for (int j = 0; j < LINES; j++) begin
        if (WAY_W'(j) == touch_way)
          age_q[j] <= '0;
        else if (age_q[j] < age_q[touch_way])
          age_q[j] <= age_q[j] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < LINES; j++) is_oldest[j] = (age_q[j] == OLDEST);
  end

  always_comb begin
    victim_way = '0;
    for (int j = LINES - 1; j >= 0; j--) begin
      if (is_oldest[j]) victim_way = WAY_W'(j);
    end
    if (!(&valid_vec)) begin
      for (int j = LINES - 1; j >= 0; j--) begin
        if (!valid_vec[j]) victim_way = WAY_W'(j);
      end
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst) $countones(is_oldest) == 1); // R5

endmodule

// File: rtl/wbc_line_data.sv
module wbc_line_data #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata_a = store[raddr_a];
  assign rdata_b = store[raddr_b];

endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 1,
  parameter int LINES  = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int BLOCK = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int WAY_W = $clog2(LINES);
  localparam int IDX_W = WAY_W + OFF_W;
  localparam int DEPTH = LINES * BLOCK;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(BLOCK - 1);

  wbc_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAY_W-1:0]  way_q;
  logic              hit_q;
  logic [OFF_W-1:0]  beat_q;
  logic              issue_done_q;
  logic              rd_pend_q;
  logic [OFF_W-1:0]  rd_beat_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              rsp_hit_q;
  logic [CNT_W-1:0]  hit_cnt_q;
  logic [CNT_W-1:0]  miss_cnt_q;

  logic                        hit;
  logic [WAY_W-1:0]            hit_way;
  logic [WAY_W-1:0]            victim_way;
  logic [LINES-1:0]            valid_vec;
  logic [LINES-1:0]            dirty_vec;
  logic [LINES-1:0][TAG_W-1:0] tag_vec;

  logic              accept;
  logic              victim_dirty;
  logic              wb_last;
  logic              fill_cap;
  logic              fill_last;
  logic              alloc_en;
  logic              dirty_en;
  logic              inval_en;
  logic [WAY_W-1:0]  inval_way;
  logic              touch_en;
  logic              dat_we;
  logic [IDX_W-1:0]  dat_waddr;
  logic [DATA_W-1:0] dat_wdata;
  logic [DATA_W-1:0] dat_rd_wb;
  logic [DATA_W-1:0] dat_rd_rsp;

  assign accept       = (state_q == ST_IDLE) && req_valid;
  assign victim_dirty = valid_vec[victim_way] && dirty_vec[victim_way];
  assign wb_last      = (state_q == ST_WRITEBACK) && (beat_q == LAST_BEAT);
  assign fill_cap     = (state_q == ST_FILL) && rd_pend_q;
  assign fill_last    = fill_cap && (rd_beat_q == LAST_BEAT);
  assign alloc_en     = fill_last;
  assign dirty_en     = (state_q == ST_RESPOND) && wr_q;
  assign touch_en     = (state_q == ST_RESPOND);

  always_comb begin
    inval_en  = 1'b0;
    inval_way = way_q;
    if (accept && !hit && !victim_dirty) begin
      inval_en  = 1'b1;
      inval_way = victim_way;
    end else if (wb_last) begin
      inval_en  = 1'b1;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = dat_rd_wb;
    case (state_q)
      ST_WRITEBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {tag_vec[way_q], beat_q};
      end
      ST_FILL: begin
        mem_req  = !issue_done_q;
        mem_addr = {addr_q[ADDR_W-1:OFF_W], beat_q};
      end
      default: ;
    endcase
  end

  always_comb begin
    dat_we    = 1'b0;
    dat_waddr = {way_q, addr_q[OFF_W-1:0]};
    dat_wdata = wdata_q;
    if (fill_cap) begin
      dat_we    = 1'b1;
      dat_waddr = {way_q, rd_beat_q};
      dat_wdata = mem_rdata;
    end else if (dirty_en) begin
      dat_we    = 1'b1;
    end
  end

  wbc_tag_array #(.LINES(LINES), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_tags (
    .clk(clk), .rst(rst),
    .lookup_tag(req_addr[ADDR_W-1:OFF_W]),
    .hit(hit), .hit_way(hit_way),
    .alloc_en(alloc_en), .alloc_way(way_q), .alloc_tag(addr_q[ADDR_W-1:OFF_W]),
    .dirty_en(dirty_en), .dirty_way(way_q),
    .inval_en(inval_en), .inval_way(inval_way),
    .valid_vec(valid_vec), .dirty_vec(dirty_vec), .tag_vec(tag_vec)
  );

  wbc_lru #(.LINES(LINES), .WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(touch_en), .touch_way(way_q),
    .valid_vec(valid_vec), .victim_way(victim_way)
  );

  wbc_line_data #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(dat_we), .waddr(dat_waddr), .wdata(dat_wdata),
    .raddr_a({way_q, beat_q}), .rdata_a(dat_rd_wb),
    .raddr_b({way_q, addr_q[OFF_W-1:0]}), .rdata_b(dat_rd_rsp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      wr_q         <= 1'b0;
      wdata_q      <= '0;
      way_q        <= '0;
      hit_q        <= 1'b0;
      beat_q       <= '0;
      issue_done_q <= 1'b0;
      rd_pend_q    <= 1'b0;
      rd_beat_q    <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_rdata_q  <= '0;
      rsp_hit_q    <= 1'b0;
      hit_cnt_q    <= '0;
      miss_cnt_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rd_pend_q   <= (state_q == ST_FILL) && mem_req;
      rd_beat_q   <= beat_q;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            if (hit) begin
              way_q     <= hit_way;
              hit_q     <= 1'b1;
              hit_cnt_q <= hit_cnt_q + 1'b1;
              state_q   <= ST_RESPOND;
            end else begin
              way_q        <= victim_way;
              hit_q        <= 1'b0;
              miss_cnt_q   <= miss_cnt_q + 1'b1;
              beat_q       <= '0;
              issue_done_q <= 1'b0;
              state_q      <= victim_dirty ? ST_WRITEBACK : ST_FILL;
            end
          end
        end
        ST_WRITEBACK: begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            beat_q       <= '0;
            issue_done_q <= 1'b0;
            state_q      <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (!issue_done_q) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) issue_done_q <= 1'b1;
          end
          if (fill_last) state_q <= ST_RESPOND;
        end
        ST_RESPOND: begin
          rsp_valid_q <= 1'b1;
          rsp_rdata_q <= wr_q ? wdata_q : dat_rd_rsp;
          rsp_hit_q   <= hit_q;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign rsp_hit    = rsp_hit_q;
  assign hit_count  = hit_cnt_q;
  assign miss_count = miss_cnt_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE || state_q == ST_RESPOND) |-> !mem_req); // R2
  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (valid_vec[way_q] && dirty_vec[way_q])); // R7
  AST_STORE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESPOND && wr_q) |=> dirty_vec[way_q]); // R3
  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESPOND && !hit_q && !wr_q) |-> (valid_vec[way_q] && !dirty_vec[way_q])); // R4
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10
  AST_RSP_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready); // R10
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(miss_cnt_q) |-> miss_cnt_q == $past(miss_cnt_q) + CNT_W'(1)); // R9
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(hit_cnt_q) |-> hit_cnt_q == $past(hit_cnt_q) + CNT_W'(1)); // R9

endmodule

// File: tb/sim_wbc_cache.sv
module sim_wbc_cache;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, rsp_hit;
  logic [7:0] rsp_rdata;
  logic       mem_req, mem_we;
  logic [4:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic [15:0] hit_count, miss_count;

  always #10 clk = ~clk;

  wbc_cache u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
  );

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;

  // backing memory and traffic monitor
  logic [7:0] m_mem [32];
  int wr_n, rd_n;
  bit order_bad;
  logic [4:0] wr_a [4];
  logic [4:0] rd_a [4];

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) m_mem[i] <= init_val(i);
    end else if (mem_req) begin
      if (mem_we) begin
        if (rd_n != 0) order_bad = 1'b1;
        if (wr_n < 4) wr_a[wr_n] = mem_addr;
        wr_n = wr_n + 1;
        m_mem[mem_addr] <= mem_wdata;
      end else begin
        if (rd_n < 4) rd_a[rd_n] = mem_addr;
        rd_n = rd_n + 1;
        mem_rdata <= m_mem[mem_addr];
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      nchk = nchk + 1;
      nerr = nerr + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nerr = nerr + 1;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // reference model
  logic [7:0] gold [32];
  logic [7:0] exp_mem [32];
  bit         c_v [2];
  bit         c_d [2];
  logic [3:0] c_tag [2];
  logic [7:0] c_data [2][2];
  int         mru = 0;
  int         m_hits = 0;
  int         m_miss = 0;

  task automatic access(input bit wr, input logic [4:0] a, input logic [7:0] d);
    logic [3:0] tg;
    bit hit;
    int w;
    bit wb;
    int waits;
    logic [7:0] exp_rd;
    tg = a[4:1];
    hit = 1'b0;
    w = 0;
    for (int i = 0; i < 2; i++) if (c_v[i] && c_tag[i] == tg) begin hit = 1'b1; w = i; end
    if (!hit) begin
      if (!c_v[0]) w = 0;
      else if (!c_v[1]) w = 1;
      else w = 1 - mru;
    end
    wb = !hit && c_v[w] && c_d[w];
    exp_rd = wr ? d : gold[a];

    @(negedge clk);
    wr_n = 0; rd_n = 0; order_bad = 1'b0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy", int'(req_ready), 0);
    waits = 0;
    while (!rsp_valid && waits < 50) begin @(negedge clk); waits++; end
    chk(rsp_valid == 1'b1, "R10 response", int'(rsp_valid), 1);
    chk(req_ready == 1'b1, "R10 ready with response", int'(req_ready), 1);
    chk(rsp_rdata == exp_rd, wr ? (hit ? "R3 data" : "R8 data") : (hit ? "R2 data" : "R4 data"),
        int'(rsp_rdata), int'(exp_rd));
    chk(rsp_hit == hit, "R5 hit flag", int'(rsp_hit), int'(hit));
    chk(rd_n == (hit ? 0 : 2), hit ? "R2 no reads on hit" : "R4 fill reads", rd_n, hit ? 0 : 2);
    chk(wr_n == (wb ? 2 : 0), wb ? "R7 writeback count" : (hit ? "R3 no write" : "R6 clean eviction"),
        wr_n, wb ? 2 : 0);
    chk(!order_bad, "R7 writeback before fill", int'(order_bad), 0);
    if (!hit) begin
      for (int b = 0; b < 2; b++)
        chk(rd_a[b] == {tg, 1'(b)}, "R4 fill address", int'(rd_a[b]), int'({tg, 1'(b)}));
    end
    if (wb) begin
      for (int b = 0; b < 2; b++) begin
        chk(wr_a[b] == {c_tag[w], 1'(b)}, "R7 writeback address", int'(wr_a[b]), int'({c_tag[w], 1'(b)}));
        exp_mem[{c_tag[w], 1'(b)}] = c_data[w][b];
      end
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 pulse", int'(rsp_valid), 0);

    if (!hit) begin
      for (int b = 0; b < 2; b++) c_data[w][b] = exp_mem[{tg, 1'(b)}];
      c_v[w] = 1'b1; c_d[w] = 1'b0; c_tag[w] = tg;
      m_miss++;
    end else m_hits++;
    if (wr) begin
      c_data[w][a[0]] = d;
      c_d[w] = 1'b1;
      gold[a] = d;
    end
    mru = w;
  endtask

  task automatic check_memory(input string rq);
    for (int i = 0; i < 32; i++)
      chk(m_mem[i] == exp_mem[i], rq, int'(m_mem[i]), int'(exp_mem[i]));
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    for (int i = 0; i < 32; i++) begin gold[i] = init_val(i); exp_mem[i] = init_val(i); end
    for (int i = 0; i < 2; i++) begin c_v[i] = 1'b0; c_d[i] = 1'b0; c_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
    chk(hit_count == 0, "R1 hit_count", int'(hit_count), 0);
    chk(miss_count == 0, "R1 miss_count", int'(miss_count), 0);

    // directed: cold misses, store hit, dirty eviction, store miss (R5 R6 R7 R8 R11)
    access(1'b0, 5'd1, 8'h00);
    access(1'b0, 5'd7, 8'h00);
    access(1'b1, 5'd0, 8'h5A);
    access(1'b1, 5'd5, 8'h3C);
    access(1'b0, 5'd10, 8'h00);
    access(1'b0, 5'd5, 8'h00);
    access(1'b1, 5'd11, 8'hC3);
    access(1'b0, 5'd0, 8'h00);
    access(1'b0, 5'd20, 8'h00);
    check_memory("R8 memory after directed");

    // exhaustive sweep: load each address twice, store each once
    for (int a = 0; a < 32; a++) begin
      access(1'b0, 5'(a), 8'h00);
      access(1'b0, 5'(a), 8'h00);
      access(1'b1, 5'(a ^ 1), 8'(a * 7 + 3));
    end
    check_memory("R7 memory after sweep");

    // random phase over four blocks, then over the full space
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[7], (n < 250) ? {2'b00, lfsr[2:0]} : lfsr[4:0], lfsr[15:8]);
    end
    check_memory("R7 memory after random");

    chk(int'(hit_count) == m_hits, "R9 hit_count", int'(hit_count), m_hits);
    chk(int'(miss_count) == m_miss, "R9 miss_count", int'(miss_count), m_miss);
    finish_run();
  end

endmodule